// File: doc/BRIEF.md
# Raster Colour-Filter Demosaic (2x2 Quad)

This block turns a raster stream of raw sensor samples into packed RGBA pixels. The samples come from a sensor whose colour filters repeat in a 2x2 tile: blue at even column and even row, red at odd column and odd row, green on the other two sites. For each position the block looks at a 2x2 quad: the pixel itself, its right neighbour, the pixel below and the pixel below-right. The parity of the pixel's column and row decides which quad sample is taken as red, which as blue and which two are averaged into green. Alpha is always full scale.

Rows arrive one sample per accepted cycle. A start-of-frame flag marks the first sample, an end-of-line flag the last sample of each row, and an end-of-frame flag the last sample of the frame. One line buffer holds the previous row, so each row of output is produced while the following row streams in. On the last column the missing right neighbours are replaced by the sample on their left, and on the last row the missing lower neighbours by the sample above them. After the end of a frame the block drains the final row from its line buffer by itself and ignores the input until the drain is over.

Top module: `bayer_quad_demosaic`

## Requirements
- R1: After reset `out_valid`, `out_sof` and `out_eol` are 0 until the first output pixel.
- R2: For output position (x,y) with quad samples TL=(x,y), TR=(x+1,y), BL=(x,y+1), BR=(x+1,y+1): x even,y even gives B=TL,R=BR,G from TR,BL; x odd,y even gives B=TR,R=BL,G from TL,BR; x even,y odd gives B=BL,R=TR,G from TL,BR; x odd,y odd gives B=BR,R=TL,G from TR,BL. Green is (Ga+Gb)>>1, truncated. `out_rgba` packs R in bits 7:0, G in 15:8, B in 23:16, alpha in 31:24.
- R3: The alpha byte of every output is 255.
- R4: Outputs come out in raster order, one per input position; the output for (x,y), x not last column, becomes valid the cycle after sample (x+1,y+1) is accepted.
- R5: Samples of a frame's first row and the first sample of any row produce no output in the following cycle.
- R6: On the last column the right neighbours are replicated from the same column; that output is flagged by `out_eol` and becomes valid two cycles after the row's last sample is accepted.
- R7: After the end-of-frame sample, the last row of the frame is emitted with its lower neighbours replicated from the row itself, after the previous row's last-column pixel, so that every frame yields width x height outputs.
- R8: From the cycle after the end-of-frame sample until the last drained pixel, `in_valid` and the other inputs are ignored.
- R9: `out_sof` is 1 only with the output for (0,0); `out_eol` only with outputs in the last column.
- R10: A sample with `in_sof` set is taken as position (0,0) even in the middle of a frame, restarting the row count.
- R11: Idle cycles (`in_valid` low) between samples do not change the outputs produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DW | Raw sample |
| in_sof | input | 1 | Sample is position (0,0) |
| in_eol | input | 1 | Sample is last of its row |
| in_eof | input | 1 | Sample is last of the frame (also ends the row) |
| out_valid | output | 1 | Output pixel present |
| out_rgba | output | 4*DW | Alpha, blue, green, red from high to low byte |
| out_sof | output | 1 | Output is position (0,0) |
| out_eol | output | 1 | Output is in the last column |

## Verification
The hard case is the frame tail: the last-column pixel of the second-to-last row and the whole drained last row appear only after the end-of-frame sample, at a time when the input is deaf. The stimulus reaches it with frames of one row, of one column and of full line-buffer width, and drives garbage samples, including false start-of-frame flags, through the whole drain window, so that any accepted garbage would show up in the following frame's output.

// File: rtl/bayer_quad_demosaic.sv
module bayer_quad_demosaic #(
  parameter int DW    = 8,
  parameter int MAX_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            in_sof,
  input  logic            in_eol,
  input  logic            in_eof,
  output logic            out_valid,
  output logic [4*DW-1:0] out_rgba,
  output logic            out_sof,
  output logic            out_eol
);
  localparam int XW = (MAX_W > 2) ? $clog2(MAX_W) : 1;

  logic [DW-1:0] lb [MAX_W];
  logic [XW-1:0] xcnt, fx, wlast;
  logic [1:0]    ycnt;
  logic          ypar, flushing, f_ypar, f_row0;
  logic          tail_pend, t_px, t_py, t_sof;
  logic [DW-1:0] t_top, t_bot, p_top, p_bot;

  wire           acc        = in_valid && !flushing;
  wire [XW-1:0]  ex         = in_sof ? '0 : xcnt;
  wire [1:0]     ey         = in_sof ? 2'd0 : ycnt;
  wire           eyp        = in_sof ? 1'b0 : ypar;
  wire [DW-1:0]  above      = lb[ex];
  wire           row_end    = in_eol || in_eof;
  wire           flush_emit = flushing && !tail_pend;
  wire [XW-1:0]  fx_r       = (fx == wlast) ? fx : fx + 1'b1;
  wire [DW-1:0]  f_l        = lb[fx];
  wire [DW-1:0]  f_r        = lb[fx_r];

  logic [DW-1:0] q [4];
  logic          px, py, vld, s_sof, s_eol;

  always_comb begin
    if (tail_pend) begin
      q[0] = t_top; q[1] = t_top; q[2] = t_bot; q[3] = t_bot;
      px = t_px; py = t_py; vld = 1'b1; s_sof = t_sof; s_eol = 1'b1;
    end else if (flush_emit) begin
      q[0] = f_l; q[1] = f_r; q[2] = f_l; q[3] = f_r;
      px = fx[0]; py = f_ypar; vld = 1'b1;
      s_sof = f_row0 && (fx == '0); s_eol = (fx == wlast);
    end else begin
      q[0] = p_top; q[1] = above; q[2] = p_bot; q[3] = in_data;
      px = ~ex[0]; py = ~eyp; vld = acc && (ex != '0) && (ey != 2'd0);
      s_sof = (ex == 1) && (ey == 2'd1); s_eol = 1'b0;
    end
  end

  wire [DW-1:0] red  = q[{~py, ~px}];
  wire [DW-1:0] blue = q[{py, px}];
  wire [DW:0]   gsum = {1'b0, q[{py, ~px}]} + {1'b0, q[{~py, px}]};

  always_ff @(posedge clk)
    if (acc) lb[ex] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eol <= 1'b0; out_rgba <= '0;
      xcnt <= '0; ycnt <= 2'd0; ypar <= 1'b0;
      flushing <= 1'b0; fx <= '0; wlast <= '0; f_ypar <= 1'b0; f_row0 <= 1'b0;
      tail_pend <= 1'b0; t_px <= 1'b0; t_py <= 1'b0; t_sof <= 1'b0;
      t_top <= '0; t_bot <= '0; p_top <= '0; p_bot <= '0;
    end else begin
      out_valid <= vld;
      out_sof   <= vld && s_sof;
      out_eol   <= vld && s_eol;
      if (vld) out_rgba <= {{DW{1'b1}}, blue, gsum[DW:1], red};

      tail_pend <= 1'b0;
      if (acc) begin
        p_top <= above;
        p_bot <= in_data;
        if (row_end) begin
          xcnt <= '0;
          ycnt <= (ey == 2'd3) ? 2'd3 : ey + 2'd1;
          ypar <= ~eyp;
          if (ey != 2'd0) begin
            tail_pend <= 1'b1;
            t_top <= above; t_bot <= in_data;
            t_px <= ex[0]; t_py <= ~eyp;
            t_sof <= (ex == '0) && (ey == 2'd1);
          end
        end else begin
          xcnt <= ex + 1'b1;
          ycnt <= ey;
          ypar <= eyp;
        end
        if (in_eof) begin
          flushing <= 1'b1; fx <= '0; wlast <= ex;
          f_ypar <= eyp; f_row0 <= (ey == 2'd0);
          xcnt <= '0; ycnt <= 2'd0; ypar <= 1'b0;
        end
      end else if (flush_emit) begin
        if (fx == wlast) flushing <= 1'b0;
        else fx <= fx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bayer_quad_demosaic_chk.sv
module bayer_quad_demosaic_chk #(
  parameter int DW = 8,
  parameter int XW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_sof,
  input logic            in_eol,
  input logic            in_eof,
  input logic            out_valid,
  input logic [4*DW-1:0] out_rgba,
  input logic            out_sof,
  input logic            out_eol,
  input logic            flushing,
  input logic            tail_pend,
  input logic [XW-1:0]   xcnt,
  input logic [1:0]      ycnt
);
  p_alpha_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rgba[4*DW-1:3*DW] == {DW{1'b1}}));

  p_first_row_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flushing && !tail_pend && (in_sof || ycnt == 2'd0)) |=> !out_valid);

  p_edge_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flushing && !in_sof && (in_eol || in_eof) && ycnt != 2'd0)
      |=> ##1 (out_valid && out_eol));

  p_drain_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushing) |=> out_valid);

  p_input_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> $stable(xcnt) && $stable(ycnt));

  p_marks_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
endmodule

bind bayer_quad_demosaic bayer_quad_demosaic_chk #(.DW(DW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eol(in_eol), .in_eof(in_eof), .out_valid(out_valid), .out_rgba(out_rgba),
  .out_sof(out_sof), .out_eol(out_eol), .flushing(flushing),
  .tail_pend(tail_pend), .xcnt(xcnt), .ycnt(ycnt)
);

// File: tb/test_bayer_quad_demosaic.sv
module test_bayer_quad_demosaic;
  localparam int DW = 8;
  localparam int MAX_W = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sof, out_eol;
  logic [4*DW-1:0] out_rgba;

  bayer_quad_demosaic #(.DW(DW), .MAX_W(MAX_W)) i_bayer_quad_demosaic (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof), .out_valid(out_valid),
    .out_rgba(out_rgba), .out_sof(out_sof), .out_eol(out_eol));

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int fr [0:511];
  logic [33:0] expq [$];
  bit done = 1'b0;

  function automatic logic [33:0] exp_pix(int x, int y, int w, int h);
    int x1, y1, tl, tr, bl, br, r, g, b;
    x1 = (x + 1 < w) ? x + 1 : x;
    y1 = (y + 1 < h) ? y + 1 : y;
    tl = fr[y*w + x]; tr = fr[y*w + x1]; bl = fr[y1*w + x]; br = fr[y1*w + x1];
    case ({y % 2 == 1, x % 2 == 1})
      2'b00: begin b = tl; r = br; g = (tr + bl) / 2; end
      2'b01: begin b = tr; r = bl; g = (tl + br) / 2; end
      2'b10: begin b = bl; r = tr; g = (tl + br) / 2; end
      default: begin b = br; r = tl; g = (tr + bl) / 2; end
    endcase
    return {(x == 0 && y == 0), (x == w - 1), 8'hFF, b[7:0], g[7:0], r[7:0]};
  endfunction

  task automatic push_frame(int w, int h);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) expq.push_back(exp_pix(x, y, w, h));
  endtask

  task automatic check(bit ok, string req, logic [33:0] got, logic [33:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (expq.size() == 0)
        check(1'b0, "R4 unexpected output", {out_sof, out_eol, out_rgba}, '0);
      else begin
        logic [33:0] e;
        e = expq.pop_front();
        check({out_sof, out_eol, out_rgba} == e, "R2/R3/R9 pixel", {out_sof, out_eol, out_rgba}, e);
      end
    end
  end

  task automatic send(int d, bit s, bit e, bit f);
    in_valid = 1'b1; in_data = d[7:0]; in_sof = s; in_eol = e; in_eof = f;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(int w, int h);
    for (int i = 0; i < w*h; i++) fr[i] = $urandom_range(0, 255);
  endtask

  // gaps: idle cycles between samples (R11); junk: garbage during drain (R8);
  // timed: directed timing checks (R4, R5, R6)
  task automatic drive(int w, int h, bit gaps, bit junk, bit timed);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        if (gaps && $urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        send(fr[y*w + x], x == 0 && y == 0, x == w - 1, x == w - 1 && y == h - 1);
        if (timed) begin
          if (y == 0 || x == 0) begin
            if (!(x == 0 && y >= 2))
              check(!out_valid, "R5 no output after first-row or first-column sample",
                    {33'd0, out_valid}, '0);
            else
              check(out_valid && out_eol, "R6 edge pixel two cycles after row end",
                    {out_sof, out_eol, out_rgba}, exp_pix(w - 1, y - 2, w, h));
          end
          if (x == 1 && y == 1)
            check(out_valid && {out_sof, out_eol, out_rgba} == exp_pix(0, 0, w, h),
                  "R4 output one cycle after below-right sample",
                  {out_sof, out_eol, out_rgba}, exp_pix(0, 0, w, h));
        end
      end
    if (junk) begin
      for (int i = 0; i < w + 1; i++) begin
        in_valid = 1'b1; in_data = $urandom_range(0, 255);
        in_sof = i[0]; in_eol = i[1]; in_eof = (i == 2);
        @(negedge clk);
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
      idle(2);
    end else idle(w + 3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(!out_valid && !out_sof && !out_eol, "R1 reset state",
          {out_sof, out_eol, 31'd0, out_valid}, '0);
    idle(3);
    check(!out_valid, "R1 idle after reset", {33'd0, out_valid}, '0);

    fill(4, 3); push_frame(4, 3); drive(4, 3, 0, 0, 1);
    fill(1, 3); push_frame(1, 3); drive(1, 3, 0, 0, 0);
    fill(5, 1); push_frame(5, 1); drive(5, 1, 0, 0, 0);
    fill(1, 1); push_frame(1, 1); drive(1, 1, 0, 0, 0);
    fill(8, 4); push_frame(8, 4); drive(8, 4, 1, 1, 0);
    check(expq.size() == 0, "R8 drain completes despite garbage", expq.size(), 0);

    // R10: abandon a frame part-way through the second row
    fill(6, 2);
    expq.push_back(exp_pix(0, 0, 6, 2));
    expq.push_back(exp_pix(1, 0, 6, 2));
    for (int x = 0; x < 6; x++) send(fr[x], x == 0, x == 5, 1'b0);
    for (int x = 0; x < 3; x++) send(fr[6 + x], 1'b0, 1'b0, 1'b0);
    idle(2);
    check(expq.size() == 0, "R10 partial frame outputs", expq.size(), 0);
    fill(6, 2); push_frame(6, 2); drive(6, 2, 0, 0, 0);

    fill(MAX_W, 3); push_frame(MAX_W, 3); drive(MAX_W, 3, 1, 1, 0);
    fill(7, 5); push_frame(7, 5); drive(7, 5, 1, 0, 0);

    idle(4);
    check(expq.size() == 0, "R7 every position emitted", expq.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog R4 run hung got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule